// File: doc/BRIEF.md
# Interrupt Translation Queue Register Front-End

This block is the software-visible register file of a message-interrupt translation unit. Through a control window it holds a global enable bit, a command-queue base register, a command write pointer that software owns, a command read pointer that only the command engine advances, and a bank of table-base registers. Each table-base register carries a read-only type field. It also serves a separate translation window whose only live register is a write-only doorbell. The block hands its decoded queue parameters, the table-base values and a one-cycle "process queue" kick to the command engine, and forwards accepted doorbell writes. Command execution and table walks are done elsewhere.

Offsets and register formats are local to this block. Size codes on both windows give log2 of the access width in bytes: 0 means 1 byte, 1 means 2, 2 means 4 and 3 means 8. A 4-byte access to a 64-bit register selects the low half at byte offset +0 and the high half at +4. The 32 data bits travel on data bits 31:0 in both directions. Illegal accesses never stall or fault the bus. They complete, return zero, and pulse a flag that exists only for logging.

Top module: `itq_regfront`

## Requirements
- R1: After reset every control-window register reads zero. The only exceptions are the table-base slots, which read their configured type in bits 58:56 and their configured entry size in bits 52:48.
- R2: A write of either half or of the whole queue base register (offset 0x80) while the unit is disabled stores the value under the mask of bit 63, bits 51:12 and bits 7:0, and resets the read pointer to zero. The same write while enabled changes nothing.
- R3: A write to the queue base register leaves the write pointer (offset 0x88, index in bits 19:5) unchanged.
- R4: A 4-byte write to offset 0x00 with bit 0 set raises q_kick for exactly the following cycle and sets q_enable. It does not change the read pointer.
- R5: A table-base slot whose stored value is zero is unimplemented. It reads zero, ignores writes, and is not a bad access.
- R6: Writes to an implemented table-base slot (offset 0x100 + 8·n) are accepted only while disabled, and bits 58:56 and 52:48 keep their value. A 4-byte write at +4 lands in bits 63:32.
- R7: A control-window access at an unmapped offset, with a size other than 4 or 8 bytes, or misaligned, returns zero. A write of that kind changes no register. Either way bad_access pulses one cycle after the request.
- R8: A translation-window read of size 2 or 4 bytes at any offset returns zero and is not flagged.
- R9: The translation window accepts only size codes 1 and 2. Any other size pulses bad_access and never produces a doorbell. A 2-byte doorbell write is zero-extended.
- R10: A doorbell write (translation offset 0x040) produces db_valid with the data one cycle later only while enabled. While disabled it is dropped silently.
- R11: Software writes to the read pointer (offset 0x90) are ignored without a bad flag. The read pointer follows eng_rd_ptr whenever eng_rd_upd is high.
- R12: q_valid, q_base_addr and q_pages are decoded from the stored base register: bit 63, bits 51:12 scaled by 4 KiB, and bits 7:0 plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_req | input | 1 | Control-window access strobe |
| ctl_we | input | 1 | Control access is a write |
| ctl_off | input | OFF_W | Control byte offset |
| ctl_size | input | 2 | Control access size code |
| ctl_wdata | input | 64 | Control write data |
| ctl_rdata | output | 64 | Control read data, one cycle after the strobe |
| xl_req | input | 1 | Translation-window access strobe |
| xl_we | input | 1 | Translation access is a write |
| xl_off | input | OFF_W | Translation byte offset |
| xl_size | input | 2 | Translation access size code |
| xl_wdata | input | 32 | Translation write data |
| xl_rdata | output | 32 | Translation read data, always zero |
| eng_rd_upd | input | 1 | Command engine updates the read pointer |
| eng_rd_ptr | input | PTR_W | New read pointer index |
| q_enable | output | 1 | Global enable |
| q_valid | output | 1 | Queue base valid bit |
| q_base_addr | output | 52 | Queue base byte address |
| q_pages | output | 9 | Queue size in 4 KiB pages |
| q_rd_ptr | output | PTR_W | Read pointer index |
| q_wr_ptr | output | PTR_W | Write pointer index |
| q_kick | output | 1 | One-cycle process-queue request |
| tbl_regs | output | 64·N_TBL | Table-base register values, slot 0 lowest |
| db_valid | output | 1 | Accepted doorbell pulse |
| db_data | output | 32 | Doorbell data |
| bad_access | output | 1 | Bad-access pulse, for logging only |

## Verification
Every 4-byte offset of the control window up to 0x17C is read after reset. This separates mapped registers, reserved holes and the implemented and unimplemented table slots by both the data and the bad flag. The register rules are then tried with full, low-half and high-half writes, in both the enabled and the disabled state. Read-pointer values come from the engine input, so a clear can be told apart from a value that was kept. The translation window is swept over all even offsets with every size code. This separates size rejection from offset handling and from the enable gating of the doorbell.

// File: rtl/itq_pkg.sv
// Shared constants, access-kind type and helpers for the translation-queue
// register front-end. Offsets are byte offsets inside each window.
package itq_pkg;
    localparam int PTR_W       = 15;   // command index, register bits 19:5
    localparam int PTR_LSB     = 5;
    localparam int CTRL_OFF    = 'h000;
    localparam int QBASE_OFF   = 'h080;
    localparam int QWPTR_OFF   = 'h088;
    localparam int QRPTR_OFF   = 'h090;
    localparam int TBL_OFF     = 'h100;
    localparam int DB_OFF      = 'h040;

    localparam logic [63:0] QBASE_WMASK = 64'h800F_FFFF_FFFF_F0FF;
    localparam logic [63:0] TBL_RO_MASK = 64'h071F_0000_0000_0000;

    typedef enum logic [1:0] {ACC_NONE, ACC_LO, ACC_HI, ACC_FULL} acc_e;

    // Classify a control access by size code and low offset bits.
    function automatic acc_e acc_kind(input logic [1:0] size, input logic [2:0] lsb);
        if (size == 2'd2 && lsb == 3'd0) return ACC_LO;
        if (size == 2'd2 && lsb == 3'd4) return ACC_HI;
        if (size == 2'd3 && lsb == 3'd0) return ACC_FULL;
        return ACC_NONE;
    endfunction

    // Merge write data into a 64-bit register for the given access kind.
    function automatic logic [63:0] merge64(input logic [63:0] old, input logic [63:0] wd,
                                            input acc_e kind);
        case (kind)
            ACC_LO:   return {old[63:32], wd[31:0]};
            ACC_HI:   return {wd[31:0], old[31:0]};
            ACC_FULL: return wd;
            default:  return old;
        endcase
    endfunction

    // Present a 64-bit register on the read bus for the given access kind.
    function automatic logic [63:0] view64(input logic [63:0] v, input acc_e kind);
        case (kind)
            ACC_LO:   return {32'h0, v[31:0]};
            ACC_HI:   return {32'h0, v[63:32]};
            ACC_FULL: return v;
            default:  return 64'h0;
        endcase
    endfunction
endpackage

// File: rtl/itq_queue_regs.sv
// Enable bit, queue base, write pointer and read pointer.
// Assumes the parent gates hit/read data with the request strobe only;
// one access per cycle on the control window.
module itq_queue_regs
    import itq_pkg::*;
#(
    parameter int OFF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    input  logic [63:0]      wdata,
    input  logic             eng_upd,
    input  logic [PTR_W-1:0] eng_ptr,
    output logic             hit,
    output logic [63:0]      rdata,
    output logic             en,
    output logic             kick,
    output logic             base_valid,
    output logic [39:0]      base_addr,
    output logic [7:0]       base_size,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr
);
    localparam int PTR_MSB = PTR_LSB + PTR_W - 1;

    acc_e             kind;
    logic [OFF_W-1:0] word;
    logic             h_ctrl, h_base, h_wptr, h_rptr;
    logic [63:0]      base_64, wptr_64, rptr_64, base_new, wptr_new;

    // Decode which register the access targets.
    always_comb begin
        kind   = acc_kind(size, off[2:0]);
        word   = {off[OFF_W-1:3], 3'b000};
        h_ctrl = req && kind == ACC_LO && word == OFF_W'(CTRL_OFF);
        h_base = req && kind != ACC_NONE && word == OFF_W'(QBASE_OFF);
        h_wptr = req && kind != ACC_NONE && word == OFF_W'(QWPTR_OFF);
        h_rptr = req && kind != ACC_NONE && word == OFF_W'(QRPTR_OFF);
        hit    = h_ctrl || h_base || h_wptr || h_rptr;
    end

    // Rebuild register images and merged write values.
    always_comb begin
        base_64  = {base_valid, 11'h0, base_addr, 4'h0, base_size};
        wptr_64  = 64'(wptr) << PTR_LSB;
        rptr_64  = 64'(rptr) << PTR_LSB;
        base_new = merge64(base_64, wdata, kind) & QBASE_WMASK;
        wptr_new = merge64(wptr_64, wdata, kind);
    end

    // Read multiplexer.
    always_comb begin
        rdata = 64'h0;
        if (h_ctrl) rdata = {63'h0, en};
        if (h_base) rdata = view64(base_64, kind);
        if (h_wptr) rdata = view64(wptr_64, kind);
        if (h_rptr) rdata = view64(rptr_64, kind);
    end

    // Register updates: enable/kick, base with pointer clear, pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en         <= 1'b0;
            kick       <= 1'b0;
            base_valid <= 1'b0;
            base_addr  <= '0;
            base_size  <= '0;
            wptr       <= '0;
            rptr       <= '0;
        end else begin
            kick <= 1'b0;
            if (we && h_ctrl) begin
                en   <= wdata[0];
                kick <= wdata[0];
            end
            if (we && h_wptr)
                wptr <= wptr_new[PTR_MSB:PTR_LSB];
            if (we && h_base && !en) begin
                base_valid <= base_new[63];
                base_addr  <= base_new[51:12];
                base_size  <= base_new[7:0];
                rptr       <= '0;
            end else if (eng_upd) begin
                rptr <= eng_ptr;
            end
        end
    end
endmodule

// File: rtl/itq_tbl_bank.sv
// Bank of table-base registers with read-only type/entry-size fields.
// A slot whose stored value is zero is unimplemented: reads zero, ignores
// writes. Assumes reset values carry a nonzero field for implemented slots.
module itq_tbl_bank
    import itq_pkg::*;
#(
    parameter int                   OFF_W   = 12,
    parameter int                   N_TBL   = 8,
    parameter logic [N_TBL*3-1:0]   TBL_TYP = '0,
    parameter logic [N_TBL*5-1:0]   TBL_ESZ = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  logic [OFF_W-1:0]   off,
    input  logic [1:0]         size,
    input  logic [63:0]        wdata,
    input  logic               en,
    output logic               hit,
    output logic [63:0]        rdata,
    output logic [N_TBL*64-1:0] regs
);
    acc_e             kind;
    logic [OFF_W-1:0] word;
    logic [N_TBL-1:0] slot_hit;
    logic [63:0]      slot_q [N_TBL];

    // Common decode of the access.
    always_comb begin
        kind = acc_kind(size, off[2:0]);
        word = {off[OFF_W-1:3], 3'b000};
    end

    for (genvar i = 0; i < N_TBL; i++) begin : g_slot
        localparam logic [63:0] RST_VAL =
            {5'h0, TBL_TYP[3*i +: 3], 3'h0, TBL_ESZ[5*i +: 5], 48'h0};

        assign slot_hit[i] = req && kind != ACC_NONE && word == OFF_W'(TBL_OFF + 8*i);
        assign regs[64*i +: 64] = slot_q[i];

        // Slot update: only implemented slots, only while disabled, RO kept.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[i] <= RST_VAL;
            else if (we && slot_hit[i] && !en && slot_q[i] != 64'h0)
                slot_q[i] <= (slot_q[i] & TBL_RO_MASK)
                           | (merge64(slot_q[i], wdata, kind) & ~TBL_RO_MASK);
        end
    end

    // Read multiplexer across slots.
    always_comb begin
        rdata = 64'h0;
        for (int i = 0; i < N_TBL; i++)
            if (slot_hit[i]) rdata = rdata | view64(slot_q[i], kind);
        hit = |slot_hit;
    end
endmodule

// File: rtl/itq_xlate_win.sv
// Translation window: write-only doorbell, everything else reserved.
// Bad flag is combinational; the parent registers it with the control one.
module itq_xlate_win
    import itq_pkg::*;
#(
    parameter int OFF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    input  logic [31:0]      wdata,
    input  logic             en,
    output logic             bad,
    output logic             db_valid,
    output logic [31:0]      db_data
);
    logic size_ok, is_db, fire;

    // Classify the access.
    always_comb begin
        size_ok = size == 2'd1 || size == 2'd2;
        is_db   = off == OFF_W'(DB_OFF);
        fire    = req && we && size_ok && is_db && en;
        bad     = req && (!size_ok || (we && !is_db));
    end

    // Register the accepted doorbell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_valid <= 1'b0;
            db_data  <= '0;
        end else begin
            db_valid <= fire;
            if (fire) db_data <= (size == 2'd1) ? {16'h0, wdata[15:0]} : wdata;
        end
    end
endmodule

// File: rtl/itq_regfront.sv
// Register front-end top: combines queue registers, table-base bank and the
// translation window; registers read data and the bad-access pulse.
module itq_regfront
    import itq_pkg::*;
#(
    parameter int                 OFF_W   = 12,
    parameter int                 N_TBL   = 8,
    parameter logic [N_TBL*3-1:0] TBL_TYP = 24'h000021,
    parameter logic [N_TBL*5-1:0] TBL_ESZ = 40'h00000001E7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_req,
    input  logic                 ctl_we,
    input  logic [OFF_W-1:0]     ctl_off,
    input  logic [1:0]           ctl_size,
    input  logic [63:0]          ctl_wdata,
    output logic [63:0]          ctl_rdata,
    input  logic                 xl_req,
    input  logic                 xl_we,
    input  logic [OFF_W-1:0]     xl_off,
    input  logic [1:0]           xl_size,
    input  logic [31:0]          xl_wdata,
    output logic [31:0]          xl_rdata,
    input  logic                 eng_rd_upd,
    input  logic [PTR_W-1:0]     eng_rd_ptr,
    output logic                 q_enable,
    output logic                 q_valid,
    output logic [51:0]          q_base_addr,
    output logic [8:0]           q_pages,
    output logic [PTR_W-1:0]     q_rd_ptr,
    output logic [PTR_W-1:0]     q_wr_ptr,
    output logic                 q_kick,
    output logic [N_TBL*64-1:0]  tbl_regs,
    output logic                 db_valid,
    output logic [31:0]          db_data,
    output logic                 bad_access
);
    logic        q_hit, t_hit, x_bad;
    logic [63:0] q_rd, t_rd;
    logic [39:0] b_addr;
    logic [7:0]  b_size;

    itq_queue_regs #(.OFF_W(OFF_W)) u_queue (
        .clk(clk), .rst_n(rst_n), .req(ctl_req), .we(ctl_we), .off(ctl_off),
        .size(ctl_size), .wdata(ctl_wdata), .eng_upd(eng_rd_upd), .eng_ptr(eng_rd_ptr),
        .hit(q_hit), .rdata(q_rd), .en(q_enable), .kick(q_kick),
        .base_valid(q_valid), .base_addr(b_addr), .base_size(b_size),
        .wptr(q_wr_ptr), .rptr(q_rd_ptr)
    );

    itq_tbl_bank #(.OFF_W(OFF_W), .N_TBL(N_TBL), .TBL_TYP(TBL_TYP), .TBL_ESZ(TBL_ESZ)) u_tbl (
        .clk(clk), .rst_n(rst_n), .req(ctl_req), .we(ctl_we), .off(ctl_off),
        .size(ctl_size), .wdata(ctl_wdata), .en(q_enable),
        .hit(t_hit), .rdata(t_rd), .regs(tbl_regs)
    );

    itq_xlate_win #(.OFF_W(OFF_W)) u_xlate (
        .clk(clk), .rst_n(rst_n), .req(xl_req), .we(xl_we), .off(xl_off),
        .size(xl_size), .wdata(xl_wdata), .en(q_enable),
        .bad(x_bad), .db_valid(db_valid), .db_data(db_data)
    );

    assign q_base_addr = {b_addr, 12'h000};
    assign q_pages     = {1'b0, b_size} + 9'd1;
    assign xl_rdata    = 32'h0;

    // Register control read data and the combined bad-access pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_rdata  <= '0;
            bad_access <= 1'b0;
        end else begin
            ctl_rdata  <= (ctl_req && !ctl_we) ? (q_rd | t_rd) : 64'h0;
            bad_access <= (ctl_req && !(q_hit || t_hit)) || x_bad;
        end
    end
endmodule

// File: rtl/itq_regfront_chk.sv
// Protocol checker for itq_regfront, attached by bind below.
module itq_regfront_chk
    import itq_pkg::*;
#(
    parameter int                 OFF_W   = 12,
    parameter int                 N_TBL   = 8,
    parameter logic [N_TBL*3-1:0] TBL_TYP = '0,
    parameter logic [N_TBL*5-1:0] TBL_ESZ = '0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ctl_req,
    input logic                ctl_we,
    input logic [OFF_W-1:0]    ctl_off,
    input logic [1:0]          ctl_size,
    input logic [63:0]         ctl_wdata,
    input logic                eng_rd_upd,
    input logic                q_enable,
    input logic [51:0]         q_base_addr,
    input logic [PTR_W-1:0]    q_rd_ptr,
    input logic [PTR_W-1:0]    q_wr_ptr,
    input logic                q_kick,
    input logic [N_TBL*64-1:0] tbl_regs,
    input logic                db_valid
);
    logic wr_base, wr_en1;

    // Recognise base writes and enable-setting writes at the port.
    always_comb begin
        wr_base = ctl_req && ctl_we && acc_kind(ctl_size, ctl_off[2:0]) != ACC_NONE
                  && {ctl_off[OFF_W-1:3], 3'b000} == OFF_W'(QBASE_OFF);
        wr_en1  = ctl_req && ctl_we && acc_kind(ctl_size, ctl_off[2:0]) == ACC_LO
                  && {ctl_off[OFF_W-1:3], 3'b000} == OFF_W'(CTRL_OFF) && ctl_wdata[0];
    end

    AST_RPTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_base && !q_enable) |=> (q_rd_ptr == '0));                      // R2
    AST_BASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        q_enable |=> $stable(q_base_addr));                                  // R2
    AST_WPTR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_base |=> $stable(q_wr_ptr));                                      // R3
    AST_KICK_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en1 |=> (q_kick && q_enable));                                    // R4
    AST_RPTR_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en1 && !eng_rd_upd) |=> $stable(q_rd_ptr));                      // R4
    AST_DB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |-> $past(q_enable));                                       // R10

    for (genvar i = 0; i < N_TBL; i++) begin : g_unimpl
        if (TBL_TYP[3*i +: 3] == 3'd0 && TBL_ESZ[5*i +: 5] == 5'd0) begin : g_chk
            AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                tbl_regs[64*i +: 64] == 64'h0);                              // R5
        end
    end
endmodule

bind itq_regfront itq_regfront_chk #(
    .OFF_W(OFF_W), .N_TBL(N_TBL), .TBL_TYP(TBL_TYP), .TBL_ESZ(TBL_ESZ)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_req(ctl_req), .ctl_we(ctl_we), .ctl_off(ctl_off),
    .ctl_size(ctl_size), .ctl_wdata(ctl_wdata), .eng_rd_upd(eng_rd_upd),
    .q_enable(q_enable), .q_base_addr(q_base_addr), .q_rd_ptr(q_rd_ptr),
    .q_wr_ptr(q_wr_ptr), .q_kick(q_kick), .tbl_regs(tbl_regs), .db_valid(db_valid)
);

// File: tb/itq_regfront_bench.sv
`timescale 1ns/1ps
// Self-checking bench: offset sweeps plus directed register-rule scenarios.
module itq_regfront_bench;
    localparam int          OFF_W = 12;
    localparam int          N_TBL = 8;
    localparam logic [23:0] TYP   = 24'h000021;      // slot0 type 1, slot1 type 4
    localparam logic [39:0] ESZ   = 40'h00000001E7;  // slot0 esz 7, slot1 esz 15
    localparam logic [63:0] RO    = 64'h071F_0000_0000_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_req = 1'b0, ctl_we = 1'b0;
    logic [OFF_W-1:0]  ctl_off = '0;
    logic [1:0]        ctl_size = '0;
    logic [63:0]       ctl_wdata = '0;
    logic [63:0]       ctl_rdata;
    logic              xl_req = 1'b0, xl_we = 1'b0;
    logic [OFF_W-1:0]  xl_off = '0;
    logic [1:0]        xl_size = '0;
    logic [31:0]       xl_wdata = '0;
    logic [31:0]       xl_rdata;
    logic              eng_rd_upd = 1'b0;
    logic [14:0]       eng_rd_ptr = '0;
    logic              q_enable, q_valid, q_kick, db_valid, bad_access;
    logic [51:0]       q_base_addr;
    logic [8:0]        q_pages;
    logic [14:0]       q_rd_ptr, q_wr_ptr;
    logic [N_TBL*64-1:0] tbl_regs;
    logic [31:0]       db_data;

    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;
    logic [63:0] r_data;
    logic        r_bad, r_kick, x_db, x_bad;
    logic [31:0] x_dbd, x_rd;

    always #2 clk = ~clk;

    itq_regfront #(.OFF_W(OFF_W), .N_TBL(N_TBL), .TBL_TYP(TYP), .TBL_ESZ(ESZ)) u_itq_regfront (
        .clk(clk), .rst_n(rst_n), .ctl_req(ctl_req), .ctl_we(ctl_we), .ctl_off(ctl_off),
        .ctl_size(ctl_size), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .xl_req(xl_req), .xl_we(xl_we), .xl_off(xl_off), .xl_size(xl_size),
        .xl_wdata(xl_wdata), .xl_rdata(xl_rdata), .eng_rd_upd(eng_rd_upd),
        .eng_rd_ptr(eng_rd_ptr), .q_enable(q_enable), .q_valid(q_valid),
        .q_base_addr(q_base_addr), .q_pages(q_pages), .q_rd_ptr(q_rd_ptr),
        .q_wr_ptr(q_wr_ptr), .q_kick(q_kick), .tbl_regs(tbl_regs),
        .db_valid(db_valid), .db_data(db_data), .bad_access(bad_access)
    );

    function automatic logic [63:0] tbl_rst(input int i);
        return {5'h0, TYP[3*i +: 3], 3'h0, ESZ[5*i +: 5], 48'h0};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One control access; results captured one cycle after the strobe.
    task automatic ctl(input logic we, input logic [OFF_W-1:0] off, input logic [1:0] sz,
                       input logic [63:0] d);
        @(negedge clk);
        ctl_req = 1'b1; ctl_we = we; ctl_off = off; ctl_size = sz; ctl_wdata = d;
        @(negedge clk);
        ctl_req = 1'b0; ctl_we = 1'b0;
        r_data = ctl_rdata; r_bad = bad_access; r_kick = q_kick;
    endtask

    task automatic xl(input logic we, input logic [OFF_W-1:0] off, input logic [1:0] sz,
                      input logic [31:0] d);
        @(negedge clk);
        xl_req = 1'b1; xl_we = we; xl_off = off; xl_size = sz; xl_wdata = d;
        @(negedge clk);
        xl_req = 1'b0; xl_we = 1'b0;
        x_db = db_valid; x_dbd = db_data; x_bad = bad_access; x_rd = xl_rdata;
    endtask

    task automatic eng(input logic [14:0] p);
        @(negedge clk);
        eng_rd_upd = 1'b1; eng_rd_ptr = p;
        @(negedge clk);
        eng_rd_upd = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] e, e1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R7: reset sweep over every 4-byte offset.
        for (int o = 0; o < 'h180; o += 4) begin
            logic [63:0] ed; logic eb;
            ed = 64'h0; eb = 1'b1;
            if (o == 0 || (o >= 'h80 && o < 'h98)) eb = 1'b0;
            if (o >= 'h100 && o < 'h140) begin
                eb = 1'b0;
                e  = tbl_rst((o - 'h100) / 8);
                ed = (o % 8 == 4) ? {32'h0, e[63:32]} : {32'h0, e[31:0]};
            end
            ctl(1'b0, OFF_W'(o), 2'd2, 64'h0);
            chk($sformatf("R1 rst data @%h", o), r_data, ed);
            chk($sformatf("R7 rst bad @%h", o), {63'h0, r_bad}, {63'h0, eb});
        end
        chk("R1 outputs idle", {q_enable, q_kick, db_valid, q_rd_ptr, q_wr_ptr},
            {3'b0, 30'h0});

        // R2 / R12: full base write while disabled.
        ctl(1'b1, 12'h080, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        ctl(1'b0, 12'h080, 2'd3, 64'h0);
        chk("R2 base masked", r_data, 64'h800F_FFFF_FFFF_F0FF);
        chk("R12 decode", {q_valid, q_base_addr, q_pages}, {1'b1, 52'hF_FFFF_FFFF_F000, 9'h100});

        // R3 setup: write pointer masked to bits 19:5.
        ctl(1'b1, 12'h088, 2'd3, 64'h0000_0000_0001_2345);
        ctl(1'b0, 12'h088, 2'd3, 64'h0);
        chk("R3 wptr masked", r_data, 64'h12340);

        // R11: engine updates, software write ignored.
        eng(15'h0055);
        ctl(1'b1, 12'h090, 2'd3, 64'hFFFF);
        chk("R11 sw rptr not bad", {63'h0, r_bad}, 64'h0);
        ctl(1'b0, 12'h090, 2'd3, 64'h0);
        chk("R11 rptr readback", r_data, 64'hAA0);

        // R2 / R3: low-half base write clears read pointer, keeps write pointer.
        ctl(1'b1, 12'h080, 2'd2, 64'h0000_1003);
        ctl(1'b0, 12'h080, 2'd3, 64'h0);
        chk("R2 base lo half", r_data, 64'h800F_FFFF_0000_1003);
        chk("R2 rptr cleared lo", {49'h0, q_rd_ptr}, 64'h0);
        chk("R3 wptr kept lo", {49'h0, q_wr_ptr}, 64'h91A);
        chk("R12 pages", {55'h0, q_pages}, 64'h4);

        eng(15'h0021);
        ctl(1'b1, 12'h084, 2'd2, 64'h0000_0001);
        ctl(1'b0, 12'h080, 2'd3, 64'h0);
        chk("R2 base hi half", r_data, 64'h0000_0001_0000_1003);
        chk("R2 rptr cleared hi", {49'h0, q_rd_ptr}, 64'h0);
        chk("R3 wptr kept hi", {49'h0, q_wr_ptr}, 64'h91A);

        // R4: enable kicks and resumes from the old read pointer.
        eng(15'h0033);
        ctl(1'b1, 12'h000, 2'd2, 64'h1);
        chk("R4 kick", {63'h0, r_kick}, 64'h1);
        @(negedge clk);
        chk("R4 kick one cycle", {63'h0, q_kick}, 64'h0);
        chk("R4 rptr resumed", {49'h0, q_rd_ptr}, 64'h33);
        ctl(1'b0, 12'h000, 2'd2, 64'h0);
        chk("R4 enable reads 1", r_data, 64'h1);

        // R2 / R6: writes locked while enabled.
        ctl(1'b1, 12'h080, 2'd3, 64'h0);
        ctl(1'b0, 12'h080, 2'd3, 64'h0);
        chk("R2 base locked", r_data, 64'h0000_0001_0000_1003);
        chk("R2 rptr untouched when locked", {49'h0, q_rd_ptr}, 64'h33);
        ctl(1'b1, 12'h100, 2'd3, 64'h0);
        chk("R6 slot locked", tbl_regs[63:0], tbl_rst(0));

        // R10 / R9: doorbell while enabled.
        xl(1'b1, 12'h040, 2'd2, 32'hCAFE_0001);
        chk("R10 db enabled", {31'h0, x_db, x_dbd}, {31'h0, 1'b1, 32'hCAFE_0001});
        xl(1'b1, 12'h040, 2'd1, 32'hCAFE_BEEF);
        chk("R9 db 2-byte", {31'h0, x_db, x_dbd}, {31'h0, 1'b1, 32'h0000_BEEF});
        xl(1'b1, 12'h040, 2'd3, 32'h1);
        chk("R9 8-byte rejected", {62'h0, x_db, x_bad}, 64'h1);
        xl(1'b1, 12'h040, 2'd0, 32'h1);
        chk("R9 1-byte rejected", {62'h0, x_db, x_bad}, 64'h1);

        // Disable: no kick; doorbell now dropped silently.
        ctl(1'b1, 12'h000, 2'd2, 64'h0);
        chk("R4 no kick on disable", {63'h0, r_kick}, 64'h0);
        xl(1'b1, 12'h040, 2'd2, 32'h5);
        chk("R10 db disabled", {62'h0, x_db, x_bad}, 64'h0);

        // R6: implemented slots, RO bits kept, half writes.
        ctl(1'b1, 12'h100, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        ctl(1'b0, 12'h100, 2'd3, 64'h0);
        chk("R6 slot0 full", r_data, tbl_rst(0) | ~RO);
        chk("R6 slot0 port", tbl_regs[63:0], tbl_rst(0) | ~RO);
        e1 = tbl_rst(1) | (64'hFFFF_FFFF_0000_0000 & ~RO);
        ctl(1'b1, 12'h10C, 2'd2, 64'hFFFF_FFFF);
        ctl(1'b0, 12'h10C, 2'd2, 64'h0);
        chk("R6 slot1 hi shift", r_data, {32'h0, e1[63:32]});
        ctl(1'b0, 12'h108, 2'd2, 64'h0);
        chk("R6 slot1 lo untouched", r_data, 64'h0);
        ctl(1'b1, 12'h108, 2'd2, 64'h1234_5678);
        chk("R6 slot1 lo write", tbl_regs[127:64], {e1[63:32], 32'h1234_5678});

        // R5: unimplemented slots stay zero.
        for (int s = 2; s < N_TBL; s++) begin
            ctl(1'b1, OFF_W'('h100 + 8*s), 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
            chk($sformatf("R5 unimpl slot%0d not bad", s), {63'h0, r_bad}, 64'h0);
            ctl(1'b1, OFF_W'('h104 + 8*s), 2'd2, 64'hFFFF_FFFF);
            ctl(1'b0, OFF_W'('h100 + 8*s), 2'd3, 64'h0);
            chk($sformatf("R5 unimpl slot%0d read", s), r_data, 64'h0);
            chk($sformatf("R5 unimpl slot%0d port", s), tbl_regs[64*s +: 64], 64'h0);
        end

        // R7: bad sizes and reserved writes.
        ctl(1'b0, 12'h000, 2'd0, 64'h0);
        chk("R7 1-byte read", {r_data[62:0], r_bad}, 64'h1);
        ctl(1'b0, 12'h084, 2'd3, 64'h0);
        chk("R7 misaligned read", {r_data[62:0], r_bad}, 64'h1);
        ctl(1'b1, 12'h004, 2'd2, 64'h1);
        chk("R7 ctrl hi half bad", {63'h0, r_bad}, 64'h1);
        chk("R7 enable unchanged", {63'h0, q_enable}, 64'h0);
        ctl(1'b1, 12'h080, 2'd1, 64'h0);
        chk("R7 2-byte write bad", {63'h0, r_bad}, 64'h1);
        ctl(1'b0, 12'h080, 2'd3, 64'h0);
        chk("R7 base kept", r_data, 64'h0000_0001_0000_1003);

        // R8 / R9: translation window sweep.
        for (int o = 0; o < 'h100; o += 2) begin
            for (int sz = 0; sz < 4; sz++) begin
                xl(1'b0, OFF_W'(o), 2'(sz), 32'h0);
                if (sz == 1 || sz == 2)
                    chk($sformatf("R8 xl read @%h sz%0d", o, sz), {31'h0, x_bad, x_rd}, 64'h0);
                else
                    chk($sformatf("R9 xl size @%h sz%0d", o, sz), {63'h0, x_bad}, 64'h1);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule